// File: doc/BRIEF.md
# Task Channel Slot Scheduler

This block decides, every clock cycle, who owns the single execution slot of a processing core that is time-shared by a set of task channels and by the CPU. A rotation pointer walks through the channel positions and then through one extra position reserved for the CPU. Each time the pointer passes that position, one round is complete. The result is a registered one-hot grant vector: bit c selects channel c, and the top bit selects the CPU.

There are two scheduling modes. In round-robin mode every channel position takes exactly one cycle. If the channel at that position is disabled or suspended, its cycle goes to the CPU. In accelerated mode the pointer jumps over channels that cannot use the slot, so the slot goes straight to the next channel that can. A channel cannot use the slot if it is disabled, suspended, or still filling the early stages of the pipeline. When no further channel in the round can use the slot, the CPU gets it and a new round starts. The mode input is sampled only when a round begins.

Top module: `slot_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, the grant vector is the CPU bit alone (bit NUM_CH), and the first round starts at channel 0.
- R2: Exactly one bit of the grant vector is set in every cycle.
- R3: In round-robin mode, pointer position p (p below NUM_CH) grants channel p (bit p) when that channel is enabled and not suspended. The pointer then moves to p+1.
- R4: In round-robin mode, the cycle of a channel that is disabled or suspended goes to the CPU, and the pointer still moves by one.
- R5: In round-robin mode the pipeline-busy input has no effect on the grant.
- R6: Every round ends with one CPU cycle, so the grant vector never shows more than NUM_CH channel grants in a row. After the CPU cycle the pointer returns to channel 0.
- R7: In accelerated mode, from pointer p the slot goes to the lowest-numbered channel c at or above p that is enabled, not suspended and not busy. The pointer then moves to c+1.
- R8: In accelerated mode, when no channel at or above the pointer qualifies, the CPU gets the cycle and a new round starts at channel 0. With no qualifying channel at all, the CPU is granted every cycle.
- R9: The mode input is sampled only in the cycle that starts a round (pointer at channel 0). A change made mid-round has no effect until the next round.
- R10: A channel is never granted unless it was enabled and not suspended at the clock edge that produced the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accel_i | input | 1 | Mode request: 0 round-robin, 1 accelerated |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_susp_i | input | NUM_CH | Per-channel suspended flag |
| ch_busy_i | input | NUM_CH | Per-channel early-pipeline-stage flag |
| grant_o | output | NUM_CH+1 | Registered one-hot grant; bit NUM_CH is the CPU |

## Verification
The hardest case to reach is a mode request that changes in the middle of a round. The old mode must keep control until the pointer wraps, and in accelerated mode that wrap can come early. A directed sequence handles round-robin mode: it raises the request at a known pointer position while one channel is busy. Under the old mode that channel keeps its slot until the round ends, and under the new mode it is skipped from then on. The random phase then toggles the request on arbitrary cycles under sparse eligibility masks, so round lengths and switch points vary widely.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  typedef enum logic {MODE_RR = 1'b0, MODE_ACCEL = 1'b1} sched_mode_e;
endpackage

// File: rtl/slot_elig.sv
module slot_elig #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] susp_i,
  input  logic [NUM_CH-1:0] busy_i,
  output logic [NUM_CH-1:0] rr_ok_o,
  output logic [NUM_CH-1:0] acc_ok_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rr_ok_o[c]  = en_i[c] & ~susp_i[c];
    assign acc_ok_o[c] = en_i[c] & ~susp_i[c] & ~busy_i[c];
  end
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
  parameter int NUM_CH = 8,
  parameter int PW     = $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH-1:0] elig_i,
  input  logic [PW-1:0]     ptr_i,
  output logic              found_o,
  output logic [PW-1:0]     idx_o
);
  // lowest qualifying channel at or above the pointer
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig_i[i] && (PW'(i) >= ptr_i)) begin
        found_o = 1'b1;
        idx_o   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/slot_ptr.sv
module slot_ptr #(
  parameter int PW = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PW-1:0]               ptr_d_i,
  input  slot_sched_pkg::sched_mode_e mode_d_i,
  output logic [PW-1:0]               ptr_q_o,
  output slot_sched_pkg::sched_mode_e mode_q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q_o  <= '0;
      mode_q_o <= slot_sched_pkg::MODE_RR;
    end else begin
      ptr_q_o  <= ptr_d_i;
      mode_q_o <= mode_d_i;
    end
  end
endmodule

// File: rtl/slot_sched.sv
module slot_sched #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accel_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] ch_susp_i,
  input  logic [NUM_CH-1:0] ch_busy_i,
  output logic [NUM_CH:0]   grant_o
);
  import slot_sched_pkg::*;

  localparam int PW = $clog2(NUM_CH + 1);
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int GW = NUM_CH + 1;
  localparam logic [PW-1:0] CPU_POS = PW'(NUM_CH);
  localparam logic [GW-1:0] CPU_GNT = GW'(1) << NUM_CH;

  logic [NUM_CH-1:0] rr_ok, acc_ok;
  logic [PW-1:0]     ptr_q, ptr_d, pick_idx;
  logic              pick_found;
  sched_mode_e       mode_q, mode_eff;
  logic [GW-1:0]     gnt_d;
  logic [CW-1:0]     ch_idx;

  slot_elig #(.NUM_CH(NUM_CH)) u_elig (
    .en_i(ch_en_i), .susp_i(ch_susp_i), .busy_i(ch_busy_i),
    .rr_ok_o(rr_ok), .acc_ok_o(acc_ok)
  );

  slot_pick #(.NUM_CH(NUM_CH), .PW(PW)) u_pick (
    .elig_i(acc_ok), .ptr_i(ptr_q),
    .found_o(pick_found), .idx_o(pick_idx)
  );

  slot_ptr #(.PW(PW)) u_ptr (
    .clk(clk), .rst(rst),
    .ptr_d_i(ptr_d), .mode_d_i(mode_eff),
    .ptr_q_o(ptr_q), .mode_q_o(mode_q)
  );

  // mode is resampled only at the start of a round
  assign mode_eff = (ptr_q == '0) ? sched_mode_e'(accel_i) : mode_q;
  assign ch_idx   = ptr_q[CW-1:0];

  always_comb begin
    gnt_d = CPU_GNT;
    ptr_d = '0;
    if (ptr_q == CPU_POS) begin
      gnt_d = CPU_GNT;
      ptr_d = '0;
    end else if (mode_eff == MODE_RR) begin
      ptr_d = ptr_q + PW'(1);
      gnt_d = rr_ok[ch_idx] ? (GW'(1) << ptr_q) : CPU_GNT;
    end else if (pick_found) begin
      gnt_d = GW'(1) << pick_idx;
      ptr_d = pick_idx + PW'(1);
    end else begin
      gnt_d = CPU_GNT;
      ptr_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) grant_o <= CPU_GNT;
    else     grant_o <= gnt_d;
  end
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_en_i,
  input logic [NUM_CH-1:0] ch_susp_i,
  input logic [NUM_CH:0]   grant_o
);
  localparam int GAPW = $clog2(NUM_CH + 2) + 1;
  logic [GAPW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || grant_o[NUM_CH]) gap <= '0;
    else                        gap <= gap + GAPW'(1);
  end

  assert_reset_cpu_R1: assert property (@(posedge clk)
    $fell(rst) |-> (grant_o == ((NUM_CH+1)'(1) << NUM_CH)));

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_o) == 1);

  assert_cpu_per_round_R6: assert property (@(posedge clk) disable iff (rst)
    !grant_o[NUM_CH] |-> (gap < GAPW'(NUM_CH)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ok
    assert_grant_ready_R10: assert property (@(posedge clk) disable iff (rst)
      grant_o[c] |-> ($past(ch_en_i[c]) && !$past(ch_susp_i[c])));
  end
endmodule

bind slot_sched slot_sched_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .ch_en_i(ch_en_i), .ch_susp_i(ch_susp_i), .grant_o(grant_o)
);

// File: tb/test_slot_sched.sv
module test_slot_sched;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         accel = 1'b0;
  logic [N-1:0] en = '0, susp = '0, busy = '0;
  logic [N:0]   grant;

  int total = 0;
  int bad = 0;
  int m_ptr = 0;
  int m_acc = 0;
  string tag_ovr = "";

  always #10 clk = ~clk;

  slot_sched #(.NUM_CH(N)) i_slot_sched (
    .clk(clk), .rst(rst), .accel_i(accel),
    .ch_en_i(en), .ch_susp_i(susp), .ch_busy_i(busy), .grant_o(grant)
  );

  // reference model from the requirements
  task automatic model(output logic [N:0] exp, output string why);
    int mode;
    int c;
    mode = (m_ptr == 0) ? int'(accel) : m_acc;
    m_acc = mode;
    exp = '0;
    if (m_ptr == N) begin
      exp[N] = 1'b1; why = "R6"; m_ptr = 0;
    end else if (mode == 0) begin
      if (en[m_ptr] && !susp[m_ptr]) begin exp[m_ptr] = 1'b1; why = "R3"; end
      else begin exp[N] = 1'b1; why = "R4"; end
      m_ptr = m_ptr + 1;
    end else begin
      c = -1;
      for (int i = N - 1; i >= m_ptr; i--)
        if (en[i] && !susp[i] && !busy[i]) c = i;
      if (c >= 0) begin exp[c] = 1'b1; why = "R7"; m_ptr = c + 1; end
      else begin exp[N] = 1'b1; why = "R8"; m_ptr = 0; end
    end
  endtask

  task automatic check(input logic [N:0] exp, input string why);
    total++;
    if (grant !== exp) begin
      bad++;
      $display("FAIL %s: grant=%b expected=%b", why, grant, exp);
    end
    total++;
    if ($countones(grant) != 1) begin
      bad++;
      $display("FAIL R2: grant=%b expected one bit set", grant);
    end
  endtask

  task automatic step();
    logic [N:0] exp;
    string why;
    model(exp, why);
    if (tag_ovr != "") why = tag_ovr;
    @(posedge clk); #1;
    check(exp, why);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    total++;
    if (grant !== (9'b1 << N)) begin
      bad++;
      $display("FAIL R1: grant=%b expected=%b", grant, 9'b1 << N);
    end
    rst = 1'b0; m_ptr = 0; m_acc = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R1: first cycle after reset is position 0
    en = '1; tag_ovr = "R1"; step(); tag_ovr = "";
    // R3/R6: full round-robin rounds
    for (int k = 0; k < 2 * (N + 1); k++) step();
    // R4: suspended and disabled slots go to CPU
    susp = 8'b0010_0100; en = 8'b0111_1111;
    for (int k = 0; k < 2 * (N + 1); k++) step();
    // R5: busy has no effect in round-robin
    susp = '0; en = '1; busy = '1; tag_ovr = "R5";
    for (int k = 0; k < N + 1; k++) step();
    tag_ovr = "";
    // R9: request accelerated mid-round, channel 3 busy
    do_reset(); busy = 8'b0000_1000;
    step(); step(); step();
    accel = 1'b1; tag_ovr = "R9";
    for (int k = 0; k < 2 * (N + 1); k++) step();
    tag_ovr = "";
    // R7/R8: single eligible channel, then none
    en = 8'b0010_0000; busy = '0;
    for (int k = 0; k < 8; k++) step();
    en = '0;
    for (int k = 0; k < 6; k++) step();
    en = '1; susp = '1;
    for (int k = 0; k < 4; k++) step();
    // random phase
    susp = '0;
    for (int k = 0; k < 3000; k++) begin
      en    = N'($urandom);
      susp  = N'($urandom) & N'($urandom);
      busy  = N'($urandom) & N'($urandom);
      if ($urandom_range(0, 15) == 0) accel = ~accel;
      step();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule